// File: doc/BRIEF.md
# Four-Port GPIO Bank with Indirect Pin Configuration

The block drives and samples 29 general-purpose pins that are grouped into four byte-wide ports. Pin n sits in port n/8 at bit n%8, so the last port holds only pins 24 to 28. A small runtime register window gives software four kinds of access: it writes the output data, reads the synchronised pad levels, enables edge events and clears latched event status. Only the first two ports carry event logic.

Each pin's electrical mode is set through a second, two-register port. A select register names one pin. A configuration register then reads or writes three mode bits for that pin: drive enable, push-pull versus open-drain, and pull-up request. Pad drive leaves the block as three vectors, one bit per pin: drive value, drive enable and pull-up request. One event line is the OR of every status bit that is set and enabled.

Top module: `gpio_quad_port`

## Requirements
- R1: After reset every pin has drive enable, push-pull and pull-up cleared and data-out 0. So pad_oe, pad_pu and pad_out are all zero, event_o is 0, and the select register reads 0x00.
- R2: Data-out for port 0, 1, 2 and 3 is written and read back at runtime offsets 0x0, 0x4, 0x8 and 0xA. Bit b of port k drives pad_out[8k+b].
- R3: Data-in for ports 0 to 3 is read at offsets 0x1, 0x5, 0x9 and 0xB. It shows pad_in through a two-flop synchroniser, whatever the pin's mode. A pad change becomes visible after the second rising clock edge.
- R4: Writing cfg_addr=0 with the value (port<<4)|bit selects pin 8*port+bit, and reading cfg_addr=0 returns that encoded value. Reading cfg_addr=1 returns the selected pin's mode byte, and writing it sets the mode byte. In the mode byte, bit 0 is drive enable, bit 1 is push-pull and bit 2 is pull-up. Bits 7:3 read as 0.
- R5: When drive enable is 0, pad_oe is 0. In push-pull mode pad_oe is 1. In open-drain mode pad_oe is 1 only while the data-out bit is 0. pad_out always equals the data-out bit.
- R6: pad_pu of each pin equals that pin's pull-up mode bit, and it changes only on a configuration-register write.
- R7: Pins 0 to 15 carry events. Event-enable is at offset 0x2 for port 0 and 0x6 for port 1. Event status is at 0x3 and 0x7. A rising or falling edge of the synchronised level on an enabled pin sets its status bit one edge after data-in changes, so the bit becomes visible after the third rising edge. A disabled pin never sets its status bit.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R9: event_o is 1 exactly when some status bit and its enable bit are both 1. Clearing the enable drops event_o but keeps the status bit.
- R10: A select write is ignored, and the old selection is kept, when bit 7 or bit 3 is set or when the encoded pin number is 29 or more.
- R11: Data-out bits above pin 28 (offset 0xA bits 7:5) are not stored and read as 0. Data-in bits 7:5 at 0xB read as 0. Offsets 0xC to 0xF read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rt_addr | input | 4 | Runtime register offset |
| rt_wr | input | 1 | Runtime write strobe |
| rt_wdata | input | 8 | Runtime write data |
| rt_rdata | output | 8 | Runtime read data (combinational) |
| cfg_addr | input | 1 | 0 = pin select, 1 = pin mode byte |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| pad_in | input | 29 | Pad levels, asynchronous |
| pad_out | output | 29 | Pad drive value |
| pad_oe | output | 29 | Pad drive enable |
| pad_pu | output | 29 | Pull-up request |
| event_o | output | 1 | OR of enabled, set status bits |

## Verification
The hardest situation to reach from the ports is the full product of pin, mode byte and data-out value on the pad outputs. Every pin can only be reached through a select write followed by a mode write. The bench walks all 29 pins through all eight mode bytes with both data-out levels and checks the three pad vectors each time. It also sweeps all 256 select values to show which ones are refused. Event timing is checked one edge at a time, for rising and falling edges, on enabled and disabled pins.

// File: rtl/gpio_quad_port.sv
module gpio_quad_port #(
  parameter int NPINS  = 29,
  parameter int EVPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       rt_addr,
  input  logic             rt_wr,
  input  logic [7:0]       rt_wdata,
  output logic [7:0]       rt_rdata,
  input  logic             cfg_addr,
  input  logic             cfg_wr,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_pu,
  output logic             event_o
);
  localparam int NPORTS = 4;
  localparam int PADW   = NPORTS * 8;
  localparam int EVP    = EVPINS / 8;
  localparam int SELW   = $clog2(NPINS);

  function automatic logic [3:0] do_addr(input int k);
    return (k < 2) ? 4'(4 * k) : 4'(8 + 2 * (k - 2));
  endfunction

  logic [NPINS-1:0]  dout_q, oe_q, pp_q, pu_q;
  logic [NPINS-1:0]  s1_q, s2_q;
  logic [EVPINS-1:0] s3_q, en_q, sts_q;
  logic [SELW-1:0]   sel_q;

  logic [PADW-1:0]   dout_w, din_w, dout_nx;
  logic [EVPINS-1:0] en_nx, clr_v, evt_edge;
  logic [5:0]        req_pin;
  logic              sel_ok;
  logic              unused_hi;

  assign dout_w    = PADW'(dout_q);
  assign din_w     = PADW'(s2_q);
  assign unused_hi = ^dout_nx[PADW-1:NPINS];

  always_comb begin
    dout_nx = dout_w;
    en_nx   = en_q;
    clr_v   = '0;
    for (int k = 0; k < NPORTS; k++)
      if (rt_wr && rt_addr == do_addr(k)) dout_nx[8*k +: 8] = rt_wdata;
    for (int k = 0; k < EVP; k++) begin
      if (rt_wr && rt_addr == 4'(4 * k + 2)) en_nx[8*k +: 8] = rt_wdata;
      if (rt_wr && rt_addr == 4'(4 * k + 3)) clr_v[8*k +: 8] = rt_wdata;
    end
  end

  always_comb begin
    rt_rdata = '0;
    for (int k = 0; k < NPORTS; k++) begin
      if (rt_addr == do_addr(k))        rt_rdata = dout_w[8*k +: 8];
      if (rt_addr == do_addr(k) + 4'd1) rt_rdata = din_w[8*k +: 8];
    end
    for (int k = 0; k < EVP; k++) begin
      if (rt_addr == 4'(4 * k + 2)) rt_rdata = en_q[8*k +: 8];
      if (rt_addr == 4'(4 * k + 3)) rt_rdata = sts_q[8*k +: 8];
    end
  end

  assign evt_edge = s2_q[EVPINS-1:0] ^ s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      en_q   <= '0;
      sts_q  <= '0;
      s1_q   <= '0;
      s2_q   <= '0;
      s3_q   <= '0;
    end else begin
      dout_q <= dout_nx[NPINS-1:0];
      en_q   <= en_nx;
      sts_q  <= (sts_q & ~clr_v) | (evt_edge & en_q);
      s1_q   <= pad_in;
      s2_q   <= s1_q;
      s3_q   <= s2_q[EVPINS-1:0];
    end
  end

  assign req_pin = {cfg_wdata[6:4], cfg_wdata[2:0]};
  assign sel_ok  = !cfg_wdata[7] && !cfg_wdata[3] && (req_pin < 6'(NPINS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      oe_q  <= '0;
      pp_q  <= '0;
      pu_q  <= '0;
    end else if (cfg_wr) begin
      if (!cfg_addr) begin
        if (sel_ok) sel_q <= SELW'(req_pin);
      end else begin
        oe_q[sel_q] <= cfg_wdata[0];
        pp_q[sel_q] <= cfg_wdata[1];
        pu_q[sel_q] <= cfg_wdata[2];
      end
    end
  end

  assign cfg_rdata = cfg_addr ? {5'b0, pu_q[sel_q], pp_q[sel_q], oe_q[sel_q]}
                              : {1'b0, 3'(sel_q >> 3), 1'b0, sel_q[2:0]};

  assign pad_out = dout_q;
  assign pad_oe  = oe_q & (pp_q | ~dout_q);
  assign pad_pu  = pu_q;
  assign event_o = |(sts_q & en_q);
endmodule

// File: rtl/gpio_quad_port_chk.sv
module gpio_quad_port_chk #(
  parameter int NPINS  = 29,
  parameter int EVPINS = 16,
  parameter int SELW   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        rt_addr,
  input logic              rt_wr,
  input logic [7:0]        rt_wdata,
  input logic [7:0]        rt_rdata,
  input logic              cfg_addr,
  input logic              cfg_wr,
  input logic [7:0]        cfg_wdata,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  pad_pu,
  input logic              event_o,
  input logic [NPINS-1:0]  pp_q,
  input logic [EVPINS-1:0] en_q,
  input logic [EVPINS-1:0] sts_q,
  input logic [EVPINS-1:0] evt_edge,
  input logic [SELW-1:0]   sel_q
);
  localparam logic [7:0] TOP_MASK = 8'((1 << (NPINS - 24)) - 1);

  assert_od_no_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_out & ~pp_q) == '0);

  assert_pullup_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && cfg_addr) |=> $stable(pad_pu));

  assert_set_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q & ~$past(sts_q) & ~$past(en_q)) == '0);

  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_wr && rt_addr == 4'h3) |=>
      ((sts_q[7:0] & $past(rt_wdata) & ~$past(evt_edge[7:0] & en_q[7:0])) == 8'h00));

  assert_event_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> (en_q != '0 && sts_q != '0));

  assert_bad_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_addr &&
     (cfg_wdata[7] || cfg_wdata[3] || {cfg_wdata[6:4], cfg_wdata[2:0]} >= 6'(NPINS)))
      |=> $stable(sel_q));

  assert_top_bits_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_addr == 4'hA || rt_addr == 4'hB) |-> (rt_rdata & ~TOP_MASK) == 8'h00);

  assert_hole_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_addr >= 4'hC) |-> rt_rdata == 8'h00);
endmodule

bind gpio_quad_port gpio_quad_port_chk #(.NPINS(NPINS), .EVPINS(EVPINS), .SELW(SELW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rt_addr(rt_addr), .rt_wr(rt_wr), .rt_wdata(rt_wdata),
  .rt_rdata(rt_rdata), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
  .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .event_o(event_o),
  .pp_q(pp_q), .en_q(en_q), .sts_q(sts_q), .evt_edge(evt_edge), .sel_q(sel_q)
);

// File: tb/tb_gpio_quad_port.sv
module tb_gpio_quad_port;
  localparam int NP = 29;
  localparam int WD_CYCLES = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    rt_addr = '0;
  logic          rt_wr = 1'b0;
  logic [7:0]    rt_wdata = '0;
  logic [7:0]    rt_rdata;
  logic          cfg_addr = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [7:0]    cfg_wdata = '0;
  logic [7:0]    cfg_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe, pad_pu;
  logic          event_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  gpio_quad_port dut (
    .clk(clk), .rst_n(rst_n), .rt_addr(rt_addr), .rt_wr(rt_wr), .rt_wdata(rt_wdata),
    .rt_rdata(rt_rdata), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .event_o(event_o)
  );

  function automatic logic [3:0] do_a(input int k);
    return (k < 2) ? 4'(4 * k) : 4'(8 + 2 * (k - 2));
  endfunction

  function automatic logic [7:0] port_mask(input int k);
    return (k == 3) ? 8'h1F : 8'hFF;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rt_w(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    rt_addr = a; rt_wdata = d; rt_wr = 1'b1;
    @(negedge clk);
    rt_wr = 1'b0;
  endtask

  task automatic rt_r(input logic [3:0] a, output logic [7:0] d);
    rt_addr = a;
    #1 d = rt_rdata;
  endtask

  task automatic cf_w(input logic a, input logic [7:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cf_r(input logic a, output logic [7:0] d);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] cur_sel;
    logic [NP-1:0] prev_in;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 pad_oe", 32'(pad_oe), 0);
    chk("R1 pad_pu", 32'(pad_pu), 0);
    chk("R1 pad_out", 32'(pad_out), 0);
    chk("R1 event_o", 32'(event_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cf_r(1'b0, rd); chk("R1 select", 32'(rd), 0);
    cf_r(1'b1, rd); chk("R1 mode byte", 32'(rd), 0);
    for (int k = 0; k < 4; k++) begin
      rt_r(do_a(k), rd); chk("R1 data-out", 32'(rd), 0);
    end

    // R4 R5 R6: every pin, every mode byte, both data-out levels
    for (int p = 0; p < NP; p++) begin
      logic [7:0] enc;
      enc = 8'(((p / 8) << 4) | (p % 8));
      cf_w(1'b0, enc);
      cf_r(1'b0, rd); chk("R4 select readback", 32'(rd), 32'(enc));
      for (int c = 0; c < 8; c++) begin
        cf_w(1'b1, 8'(c) | 8'hF8);
        cf_r(1'b1, rd); chk("R4 mode readback", 32'(rd), 32'(c));
        for (int d = 0; d < 2; d++) begin
          logic eoe;
          rt_w(do_a(p / 8), 8'(d << (p % 8)));
          eoe = c[0] & (c[1] | (d == 0));
          chk("R5 pad_out", 32'(pad_out[p]), 32'(d));
          chk("R5 pad_oe", 32'(pad_oe[p]), 32'(eoe));
          chk("R6 pad_pu", 32'(pad_pu[p]), 32'(c[2]));
        end
      end
      cf_w(1'b1, 8'h00);
      rt_w(do_a(p / 8), 8'h00);
      chk("R5 others undriven", 32'(pad_oe), 0);
    end

    // R10 sweep of all select values
    cf_w(1'b0, 8'h12);
    cur_sel = 8'h12;
    for (int v = 0; v < 256; v++) begin
      logic [7:0] vv;
      int pin;
      vv = 8'(v);
      pin = int'(vv[6:4]) * 8 + int'(vv[2:0]);
      cf_w(1'b0, vv);
      if (!vv[7] && !vv[3] && pin < NP) cur_sel = vv;
      cf_r(1'b0, rd); chk("R10 select sweep", 32'(rd), 32'(cur_sel));
    end

    // R2 data-out mapping and R11 top bits
    for (int k = 0; k < 4; k++) begin
      logic [7:0] pat;
      pat = 8'hA5 ^ 8'(k * 8'h3C);
      rt_w(do_a(k), pat);
      rt_r(do_a(k), rd); chk("R2 data-out readback", 32'(rd), 32'(pat & port_mask(k)));
      chk("R2 pad_out slice", 32'((PADW_ext(pad_out) >> (8 * k)) & 32'hFF), 32'(pat & port_mask(k)));
    end
    rt_w(4'hA, 8'hFF);
    rt_r(4'hA, rd); chk("R11 data-out top bits", 32'(rd), 32'h1F);
    chk("R11 pad_out top", 32'(pad_out[28:24]), 32'h1F);
    for (int a = 12; a < 16; a++) begin
      rt_r(4'(a), rd); chk("R11 hole read", 32'(rd), 0);
    end
    for (int k = 0; k < 4; k++) rt_w(do_a(k), 8'h00);

    // R3 synchroniser timing over patterns
    prev_in = '0;
    for (int t = 0; t < NP + 2; t++) begin
      logic [NP-1:0] pat;
      pat = (t < NP) ? (NP'(1) << t) : ((t == NP) ? '1 : NP'(29'h0AAAAAAA));
      @(negedge clk);
      pad_in = pat;
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        rt_r(do_a(k) + 4'd1, rd);
        chk("R3 data-in after one edge", 32'(rd), (PADW_ext(prev_in) >> (8 * k)) & 32'hFF);
      end
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        rt_r(do_a(k) + 4'd1, rd);
        chk("R3 data-in after two edges", 32'(rd), (PADW_ext(pat) >> (8 * k)) & 32'hFF);
      end
      prev_in = pat;
    end
    rt_r(4'hB, rd); chk("R11 data-in top bits", 32'(rd & 8'hE0), 0);

    // R7 R8 R9 events
    @(negedge clk);
    pad_in = '0;
    repeat (4) @(negedge clk);
    rt_w(4'h3, 8'hFF);
    rt_w(4'h7, 8'hFF);
    rt_w(4'h2, 8'h0F);
    rt_w(4'h6, 8'h80);
    chk("R9 idle event", 32'(event_o), 0);
    pad_in = NP'(29'h1000_8013);
    @(negedge clk);
    @(negedge clk);
    rt_r(4'h3, rd); chk("R7 status not yet set", 32'(rd), 0);
    @(negedge clk);
    rt_r(4'h3, rd); chk("R7 rising status port0", 32'(rd), 32'h03);
    rt_r(4'h7, rd); chk("R7 rising status port1", 32'(rd), 32'h80);
    chk("R9 event asserted", 32'(event_o), 1);
    rt_w(4'h3, 8'h01);
    rt_r(4'h3, rd); chk("R8 clear one bit", 32'(rd), 32'h02);
    rt_w(4'h3, 8'h00);
    rt_r(4'h3, rd); chk("R8 zero write keeps", 32'(rd), 32'h02);
    rt_w(4'h3, 8'h02);
    rt_r(4'h3, rd); chk("R8 cleared", 32'(rd), 0);
    chk("R9 port1 still pending", 32'(event_o), 1);
    rt_w(4'h6, 8'h00);
    chk("R9 disable drops event", 32'(event_o), 0);
    rt_r(4'h7, rd); chk("R9 status kept", 32'(rd), 32'h80);
    pad_in = NP'(29'h1000_8012);
    repeat (3) @(negedge clk);
    rt_r(4'h3, rd); chk("R7 falling edge", 32'(rd), 32'h01);
    chk("R9 event from fall", 32'(event_o), 1);
    rt_w(4'h3, 8'h01);
    chk("R9 event cleared", 32'(event_o), 0);

    summary();
    $finish;
  end

  function automatic logic [31:0] PADW_ext(input logic [NP-1:0] v);
    return 32'(v);
  endfunction
endmodule